// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit keeps the 8-bit status byte of a serial non-volatile memory and decides, from one cycle to the next, whether a status write or an array write may go ahead. A serial command decoder gives it one-cycle strobes for set-enable, clear-enable and status-write, along with the incoming data byte and the array address in question. A write sequencer gives it a busy level and a one-cycle completion pulse. The unit returns the byte to show on a status read, plus two permission flags that the decoder and sequencer use before they start a write cycle.

Three protection layers apply together:
- a write-enable latch that opens one modification at a time;
- a lock that freezes the protection fields while an external pin is low and the lock-enable bit is set;
- an address-range decode that shields the top quarter, the top half or the whole array.

Protection fields written by a status write are staged. They reach the readable register only when the sequencer reports the end of the write cycle.

Top module: `stat_protect_unit`

## Requirements
- R1: When `seq_busy` is low, `stat_byte` reads bit 7 = lock-enable, bits 6..4 = 0, bits 3..2 = block-protect code (bit 3 high), bit 1 = write-enable latch, bit 0 = 0.
- R2: While `seq_busy` is high, `stat_byte` reads 8'hFF.
- R3: The write-enable latch is 0 after reset. An `op_wren` strobe sets it, and the new value is visible the following cycle. It is cleared in the same way by `op_wrdi`, or by a `seq_done` pulse. If `op_wren` and `op_wrdi` arrive together, the clear wins.
- R4: `op_wren`, `op_wrdi` and `op_wrsr` have no effect in a cycle where `seq_busy` or `seq_done` is high.
- R5: `stat_wr_ok` is high exactly when the write-enable latch is 1 and hardware lock is off. Hardware lock is on when `wp_n` is 0 and lock-enable is 1. An `op_wrsr` strobe seen while `stat_wr_ok` is low changes nothing.
- R6: An accepted `op_wrsr` stages `wr_byte[7]` as lock-enable and `wr_byte[3:2]` as the block-protect code. These values appear in the register only after the next `seq_done`. The other data bits are discarded.
- R7: `arr_wr_ok` is 0 whenever the write-enable latch is 0.
- R8: With the latch set, `arr_wr_ok` is 0 for addresses in the protected range and 1 elsewhere. The ranges are: code 00 none; code 01 the top quarter (3000h–3FFFh at 14 address bits); code 10 the top half (2000h–3FFFh); code 11 the whole array.
- R9: Hardware lock has no effect on `arr_wr_ok`.
- R10: After reset, lock-enable and the block-protect code are 0, so `stat_byte` reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| op_wren | input | 1 | Set-enable strobe |
| op_wrdi | input | 1 | Clear-enable strobe |
| op_wrsr | input | 1 | Status-write strobe carrying `wr_byte` |
| wr_byte | input | 8 | Data byte of a status write |
| arr_addr | input | ADDR_W | Array address to be judged |
| seq_busy | input | 1 | Internal write cycle in progress |
| seq_done | input | 1 | One-cycle pulse at write-cycle end |
| stat_byte | output | 8 | Status byte for reads |
| stat_wr_ok | output | 1 | A status write may proceed |
| arr_wr_ok | output | 1 | A write to `arr_addr` may proceed |

## Verification
Both permission flags and the status byte are combinational views of the registered state. They are therefore due in the same cycle their inputs are applied. A strobe or completion pulse changes the stored state at the next rising edge, so its effect is due one cycle later. The bench applies inputs on the falling edge and compares all three outputs against its reference model 1 ns later. It then advances the model by what the coming rising edge will do, so every comparison uses the state that sits in the registers at that moment.

// File: rtl/prot_pkg.sv
// Shared types for the status-register protection unit.
// Assumes: the block-protect code is two bits whose values the range decoder interprets.
package prot_pkg;

    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_e;

    typedef struct packed {
        logic wpen;
        bp_e  bp;
    } prot_cfg_t;

    localparam int STAT_W      = 8;
    localparam int BIT_LOCKEN  = 7;
    localparam int BIT_BP_HI   = 3;
    localparam int BIT_BP_LO   = 2;
    localparam int BIT_WEN     = 1;

endpackage

// File: rtl/wen_latch.sv
// Write-enable latch.
// Set by the enable strobe and cleared by the disable strobe or at the end of any write cycle.
// Assumes: strobes are one-cycle pulses from the command decoder and are ignored while the sequencer is busy.
module wen_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic seq_busy,
    input  logic seq_done,
    output logic wen
);

    logic cmd_window;

    // Strobes count only when no write cycle is running or ending.
    always_comb cmd_window = !seq_busy && !seq_done;

    // Latch update: completion clears, then clear beats set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen <= 1'b0;
        end else if (seq_done) begin
            wen <= 1'b0;
        end else if (cmd_window) begin
            if (clr_req) begin
                wen <= 1'b0;
            end else if (set_req) begin
                wen <= 1'b1;
            end
        end
    end

    assert_wen_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done || (clr_req && cmd_window)) |=> !wen);

    assert_busy_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !seq_done) |=> $stable(wen));

endmodule

// File: rtl/prot_regs.sv
// Protection fields of the status register, with a staging copy.
// An accepted status write fills the staging copy, and the next write-cycle completion commits it.
// Assumes: `allow` already folds in the write-enable latch and hardware lock.
module prot_regs
    import prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic [7:0] wr_byte,
    input  logic       allow,
    input  logic       seq_busy,
    input  logic       seq_done,
    output prot_cfg_t  cfg
);

    prot_cfg_t staged;
    logic      pending;
    logic      accept;

    // A status write is taken only when permitted and outside a write cycle.
    always_comb accept = wr_req && allow && !seq_busy && !seq_done;

    // Staging copy: capture the lock-enable and block-protect fields, drop the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged  <= '0;
            pending <= 1'b0;
        end else if (seq_done) begin
            pending <= 1'b0;
        end else if (accept) begin
            staged.wpen <= wr_byte[BIT_LOCKEN];
            staged.bp   <= bp_e'(wr_byte[BIT_BP_HI:BIT_BP_LO]);
            pending     <= 1'b1;
        end
    end

    // Visible fields: factory state on reset, commit at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (seq_done && pending) begin
            cfg <= staged;
        end
    end

    assert_commit_only_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done |=> $stable(cfg));

    assert_denied_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !accept) |=> !pending);

endmodule

// File: rtl/range_check.sv
// Address-range decode for block protection.
// Reports whether an array address falls inside the region selected by the block-protect code.
// Assumes: the address covers the whole array, so the bounds are fractions of 2**ADDR_W.
module range_check
    import prot_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  bp_e               bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W - 2);

    // Compare the address against the lower bound of the chosen region.
    always_comb begin
        unique case (bp)
            BP_NONE:    hit = 1'b0;
            BP_QUARTER: hit = (addr >= QUARTER_BASE);
            BP_HALF:    hit = (addr >= HALF_BASE);
            BP_ALL:     hit = 1'b1;
            default:    hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/stat_protect_unit.sv
// Status-register write-protection unit.
// Holds the status byte and judges every status write and array write.
// Assumes: decoder strobes are one-cycle pulses, seq_busy is high for the whole internal write cycle,
// and seq_done pulses once at its end.
module stat_protect_unit
    import prot_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              op_wren,
    input  logic              op_wrdi,
    input  logic              op_wrsr,
    input  logic [7:0]        wr_byte,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              seq_busy,
    input  logic              seq_done,
    output logic [7:0]        stat_byte,
    output logic              stat_wr_ok,
    output logic              arr_wr_ok
);

    logic      wen;
    logic      hw_lock;
    logic      in_block;
    prot_cfg_t cfg;

    wen_latch u_wen (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (op_wren),
        .clr_req  (op_wrdi),
        .seq_busy (seq_busy),
        .seq_done (seq_done),
        .wen      (wen)
    );

    prot_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (op_wrsr),
        .wr_byte  (wr_byte),
        .allow    (stat_wr_ok),
        .seq_busy (seq_busy),
        .seq_done (seq_done),
        .cfg      (cfg)
    );

    range_check #(.ADDR_W(ADDR_W)) u_range (
        .bp   (cfg.bp),
        .addr (arr_addr),
        .hit  (in_block)
    );

    // Permissions: the pin lock guards only the status fields, the range guards only the array.
    always_comb begin
        hw_lock    = !wp_n && cfg.wpen;
        stat_wr_ok = wen && !hw_lock;
        arr_wr_ok  = wen && !in_block;
    end

    // Read view: all ones during a write cycle, otherwise the packed fields.
    always_comb begin
        if (seq_busy) begin
            stat_byte = 8'hFF;
        end else begin
            stat_byte = {cfg.wpen, 3'b000, cfg.bp, wen, 1'b0};
        end
    end

    assert_arr_needs_wen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok |-> u_wen.wen);

    assert_stat_needs_wen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !u_wen.wen |-> !stat_wr_ok);

    assert_full_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (u_regs.cfg.bp == BP_ALL) |-> !arr_wr_ok);

endmodule

// File: tb/stat_protect_unit_tb.sv
module stat_protect_unit_tb;

    localparam int ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wp_n;
    logic              op_wren, op_wrdi, op_wrsr;
    logic [7:0]        wr_byte;
    logic [ADDR_W-1:0] arr_addr;
    logic              seq_busy, seq_done;
    logic [7:0]        stat_byte;
    logic              stat_wr_ok, arr_wr_ok;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state.
    logic       m_wen, m_wpen, m_pend, s_wpen;
    logic [1:0] m_bp, s_bp;

    always #5 clk = ~clk;

    stat_protect_unit #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .op_wren(op_wren), .op_wrdi(op_wrdi), .op_wrsr(op_wrsr),
        .wr_byte(wr_byte), .arr_addr(arr_addr),
        .seq_busy(seq_busy), .seq_done(seq_done),
        .stat_byte(stat_byte), .stat_wr_ok(stat_wr_ok), .arr_wr_ok(arr_wr_ok)
    );

    function automatic logic in_range(input logic [1:0] bp, input logic [ADDR_W-1:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= (ADDR_W'(3) << (ADDR_W - 2));
            2'b10:   return a >= (ADDR_W'(1) << (ADDR_W - 1));
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_stat();
        if (seq_busy) return 8'hFF;                       // R2
        return {m_wpen, 3'b000, m_bp, m_wen, 1'b0};        // R1
    endfunction

    function automatic logic exp_sok();
        return m_wen && !(!wp_n && m_wpen);               // R5
    endfunction

    function automatic logic exp_aok();
        return m_wen && !in_range(m_bp, arr_addr);        // R7 R8 R9
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check 1 ns later, then advance the model for the rising edge.
    task automatic step(input logic rn, input logic wp, input logic en, input logic di,
                        input logic sr, input logic [7:0] d, input logic [ADDR_W-1:0] a,
                        input logic bz, input logic dn);
        logic acc;
        @(negedge clk);
        rst_n = rn; wp_n = wp; op_wren = en; op_wrdi = di; op_wrsr = sr;
        wr_byte = d; arr_addr = a; seq_busy = bz; seq_done = dn;
        #1;
        if (rst_n) begin
            check(seq_busy ? "R2" : "R1 R6 R10", stat_byte, exp_stat());
            check("R5", {7'd0, stat_wr_ok}, {7'd0, exp_sok()});
            check(m_wen ? "R8 R9" : "R7", {7'd0, arr_wr_ok}, {7'd0, exp_aok()});
        end
        acc = sr && exp_sok() && !bz && !dn;
        if (!rn) begin
            m_wen = 0; m_wpen = 0; m_bp = 0; m_pend = 0; s_wpen = 0; s_bp = 0;
        end else if (dn) begin                            // R3 R6
            if (m_pend) begin m_wpen = s_wpen; m_bp = s_bp; end
            m_pend = 0; m_wen = 0;
        end else if (!bz) begin                           // R4
            if (acc) begin s_wpen = d[7]; s_bp = d[3:2]; m_pend = 1; end
            if (di) m_wen = 0;
            else if (en) m_wen = 1;
        end
    endtask

    task automatic idle(input logic [ADDR_W-1:0] a, input logic wp);
        step(1, wp, 0, 0, 0, 8'h00, a, 0, 0);
    endtask

    // Enable, status write, then a write cycle with its completion pulse.
    task automatic set_status(input logic [7:0] d, input logic wp);
        step(1, wp, 1, 0, 0, 8'h00, '0, 0, 0);
        step(1, wp, 0, 0, 1, d, '0, 0, 0);
        step(1, wp, 0, 0, 0, 8'h00, '0, 1, 0);
        step(1, wp, 0, 0, 0, 8'h00, '0, 1, 1);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] edges [6];
        void'($urandom(32'd1234));
        edges[0] = '0;
        edges[1] = (ADDR_W'(1) << (ADDR_W - 1)) - 1;
        edges[2] = ADDR_W'(1) << (ADDR_W - 1);
        edges[3] = (ADDR_W'(3) << (ADDR_W - 2)) - 1;
        edges[4] = ADDR_W'(3) << (ADDR_W - 2);
        edges[5] = '1;

        // R10: reset state.
        step(0, 1, 0, 0, 0, 8'h00, '0, 0, 0);
        step(0, 1, 0, 0, 0, 8'h00, '0, 0, 0);
        idle('0, 1);

        // R7: without enable every address is refused.
        idle(14'h0000, 1);

        // R3: enable, then disable wins over a simultaneous enable.
        step(1, 1, 1, 0, 0, 8'h00, '0, 0, 0);
        idle(14'h0000, 1);
        step(1, 1, 1, 1, 0, 8'h00, '0, 0, 0);
        idle(14'h0000, 1);

        // R4: strobes during busy are dropped.
        step(1, 1, 1, 0, 0, 8'h00, '0, 1, 0);
        idle(14'h0000, 1);

        // R6: staged fields stay hidden until completion, unused bits dropped.
        step(1, 1, 1, 0, 0, 8'h00, '0, 0, 0);
        step(1, 1, 0, 0, 1, 8'h74, '0, 0, 0);
        idle(14'h0000, 1);
        step(1, 1, 0, 0, 0, 8'h00, '0, 1, 1);
        idle(14'h0000, 1);

        // R8: range boundaries for each code.
        for (int c = 0; c < 4; c++) begin
            set_status(8'(c << 2), 1);
            step(1, 1, 1, 0, 0, 8'h00, '0, 0, 0);
            for (int e = 0; e < 6; e++) idle(edges[e], 1);
        end

        // R5 R9: lock-enable with pin low blocks status writes but not the array.
        set_status(8'h84, 1);
        step(1, 0, 1, 0, 0, 8'h00, '0, 0, 0);
        step(1, 0, 0, 0, 1, 8'h00, edges[0], 0, 0);
        step(1, 0, 0, 0, 0, 8'h00, edges[2], 1, 1);
        idle(edges[3], 0);
        idle(edges[4], 1);

        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            logic [ADDR_W-1:0] a;
            logic bz, dn;
            a  = ($urandom % 2) ? edges[$urandom % 6] : ADDR_W'($urandom);
            bz = ($urandom % 5) == 0;
            dn = ($urandom % 8) == 0;
            step(($urandom % 300) != 0, $urandom % 2,
                 ($urandom % 3) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
                 8'($urandom), a, bz, dn);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule